// File: doc/BRIEF.md
# Indirect Operand Address Generator

This block forms memory operand addresses for register-indirect accesses in a 16-bit processor that has eight registers. The decoder hands it an access request: a register index, a direction, the register's current value and, for stores, the data to write. The block drives one bus access (or two), waits out any wait states, and returns the operand together with the updated register value. The register file needs that value because some registers change as a side effect of being used as a pointer.

Registers 0 to 3 are plain pointers. Registers 4 and 5 step forward after every use. Register 6 is a stack pointer: it steps down before a store and steps up after a load. Register 7 is the program counter, so an immediate operand is simply a load through it. A store through register 7 leaves it unchanged.

A one-shot paired-byte flag, raised by a dedicated instruction, makes the next load build its 16-bit operand from the low bytes of two successive reads. The low half comes first. The pointer rule is applied after each of the two reads. The flag drops when the following instruction ends.

Top module: `indirect_addr_gen`

## Requirements
- R1: For register indices 0 to 3, the bus address equals the supplied pointer and wb_en stays low at completion.
- R2: For indices 4 and 5, the bus address equals the pointer on both loads and stores, and completion reports wb_en high with wb_val equal to pointer+1 (modulo 2^16).
- R3: For index 6, a load uses the pointer as address and writes back pointer+1. A store uses pointer-1 as both the address and the write-back value.
- R4: For index 7, a load uses the pointer as address and writes back pointer+1. A store uses the pointer as address and leaves wb_en low.
- R5: A store is exactly one beat with bus_wr high and bus_wdata equal to req_wdata, even when paired-byte mode is active. bus_rd and bus_wr are never high together.
- R6: A pair_set pulse makes pair_mode high from the next cycle. An instr_end pulse clears it from the next cycle. If both pulses arrive in the same cycle, pair_set wins.
- R7: A load with pair_mode high takes two beats. The second address is the pointer after the first post-modify. The operand is {second_read[7:0], first_read[7:0]}, and the write-back value has had the rule applied twice.
- R8: A load without paired-byte mode takes one beat and returns the full 16-bit read data as the operand.
- R9: While bus_rdy is low, the active strobe and bus_addr hold their values. A beat completes on a clock edge at which bus_rdy is high.
- R10: done is a single-cycle pulse in the cycle after the final beat completes. wb_en, wb_reg and wb_val are valid in that cycle.
- R11: req_valid is ignored while an access is in progress. No extra beats or done pulses follow.
- R12: After reset, done, wb_en, bus_rd, bus_wr and pair_mode are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an access (accepted when idle) |
| req_reg | input | 3 | Pointer register index |
| req_write | input | 1 | 1 = store, 0 = load |
| req_ptr | input | 16 | Current value of the pointer register |
| req_wdata | input | 16 | Store data |
| pair_set | input | 1 | Raise paired-byte mode |
| instr_end | input | 1 | Current instruction finished; drops paired-byte mode |
| bus_rdata | input | 16 | Read data, valid while bus_rd is high |
| bus_rdy | input | 1 | Bus data ready; low inserts a wait state |
| bus_addr | output | 16 | Memory address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| done | output | 1 | Operand access complete (one cycle) |
| operand | output | 16 | Assembled load operand |
| wb_en | output | 1 | Pointer register must be updated |
| wb_reg | output | 3 | Register to update |
| wb_val | output | 16 | New pointer value |
| pair_mode | output | 1 | Paired-byte mode active |

## Verification
A wrong post-modify rule shows up as a wrong wb_val or wb_en on the done pulse of that same access. In paired-byte loads it shows up one beat earlier, as a wrong second bus address. A stuck or mis-cleared paired-byte flag changes the beat count of the next load, so the fault is visible within a single access. A sequencer that lets go during a wait state moves bus_addr or drops the strobe in the very cycle bus_rdy is low. Stimulus mixes random registers, pointers, directions and ready stalls with directed cases at pointer wrap and at flag set/clear collisions.

// File: rtl/iag_pkg.sv
package iag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/iag_post_mod.sv
module iag_post_mod #(
  parameter int AW     = 16,
  parameter int RIW    = 3,
  parameter int INC_A  = 4,
  parameter int INC_B  = 5,
  parameter int SP_IDX = 6,
  parameter int PC_IDX = 7
) (
  input  logic [AW-1:0]  ptr_i,
  input  logic [RIW-1:0] idx_i,
  input  logic           wr_i,
  output logic [AW-1:0]  addr_o,
  output logic [AW-1:0]  next_o,
  output logic           mod_o
);
  localparam logic [RIW-1:0] IA = RIW'(INC_A);
  localparam logic [RIW-1:0] IB = RIW'(INC_B);
  localparam logic [RIW-1:0] SP = RIW'(SP_IDX);
  localparam logic [RIW-1:0] PC = RIW'(PC_IDX);
  localparam logic [AW-1:0]  ONE = AW'(1);

  logic [AW-1:0] up, dn;
  assign up = ptr_i + ONE;
  assign dn = ptr_i - ONE;

  always_comb begin
    addr_o = ptr_i;
    next_o = ptr_i;
    mod_o  = 1'b0;
    if (idx_i == IA || idx_i == IB) begin
      next_o = up;
      mod_o  = 1'b1;
    end else if (idx_i == SP) begin
      mod_o = 1'b1;
      if (wr_i) begin
        addr_o = dn;
        next_o = dn;
      end else begin
        next_o = up;
      end
    end else if (idx_i == PC && !wr_i) begin
      next_o = up;
      mod_o  = 1'b1;
    end
  end
endmodule

// File: rtl/iag_pair_flag.sv
module iag_pair_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst) set_i |=> flag_o); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !flag_o); // R6
endmodule

// File: rtl/iag_seq.sv
module iag_seq
  import iag_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int BW  = 8,
  parameter int RIW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [RIW-1:0] req_reg,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  input  logic           pair_flag,
  input  logic [AW-1:0]  rule_addr,
  input  logic [AW-1:0]  rule_next,
  input  logic           rule_mod,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_rdy,
  output logic           idle,
  output logic [AW-1:0]  cur_ptr,
  output logic [RIW-1:0] cur_reg,
  output logic           cur_write,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_rd,
  output logic           bus_wr,
  output logic [DW-1:0]  bus_wdata,
  output logic           done,
  output logic [DW-1:0]  operand,
  output logic           wb_en
);
  seq_state_t    state;
  logic          dbl;
  logic          mod;
  logic [BW-1:0] lo_byte;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_ptr   <= '0;
      cur_reg   <= '0;
      cur_write <= 1'b0;
      dbl       <= 1'b0;
      mod       <= 1'b0;
      lo_byte   <= '0;
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      done      <= 1'b0;
      operand   <= '0;
      wb_en     <= 1'b0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_reg   <= req_reg;
            cur_write <= req_write;
            dbl       <= pair_flag && !req_write;
            mod       <= rule_mod;
            bus_addr  <= rule_addr;
            cur_ptr   <= rule_next;
            bus_rd    <= !req_write;
            bus_wr    <= req_write;
            bus_wdata <= req_wdata;
            state     <= ST_LO;
          end
        end
        ST_LO: begin
          if (bus_rdy) begin
            if (dbl) begin
              lo_byte  <= bus_rdata[BW-1:0];
              bus_addr <= rule_addr;
              cur_ptr  <= rule_next;
              state    <= ST_HI;
            end else begin
              bus_rd <= 1'b0;
              bus_wr <= 1'b0;
              done   <= 1'b1;
              wb_en  <= mod;
              if (!cur_write) operand <= bus_rdata;
              state  <= ST_IDLE;
            end
          end
        end
        ST_HI: begin
          if (bus_rdy) begin
            bus_rd  <= 1'b0;
            done    <= 1'b1;
            wb_en   <= mod;
            operand <= {bus_rdata[BW-1:0], lo_byte};
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr)); // R5
  AST_WR_ONE_BEAT: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_rdy) |=> !bus_wr); // R5
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && !bus_rdy) |=> ((bus_rd || bus_wr) && $stable(bus_addr))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(bus_rdy) && ($past(bus_rd) || $past(bus_wr)))); // R10
  AST_WB_ONLY_DONE: assert property (@(posedge clk) disable iff (rst) wb_en |-> done); // R10
endmodule

// File: rtl/indirect_addr_gen.sv
module indirect_addr_gen #(
  parameter int AW  = 16,
  parameter int BW  = 8,
  parameter int RIW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [RIW-1:0]    req_reg,
  input  logic              req_write,
  input  logic [AW-1:0]     req_ptr,
  input  logic [2*BW-1:0]   req_wdata,
  input  logic              pair_set,
  input  logic              instr_end,
  input  logic [2*BW-1:0]   bus_rdata,
  input  logic              bus_rdy,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [2*BW-1:0]   bus_wdata,
  output logic              done,
  output logic [2*BW-1:0]   operand,
  output logic              wb_en,
  output logic [RIW-1:0]    wb_reg,
  output logic [AW-1:0]     wb_val,
  output logic              pair_mode
);
  localparam int DW   = 2 * BW;
  localparam int NREG = 1 << RIW;

  logic           idle;
  logic [AW-1:0]  cur_ptr;
  logic [RIW-1:0] cur_reg;
  logic           cur_write;
  logic [AW-1:0]  r_ptr, r_addr, r_next;
  logic [RIW-1:0] r_idx;
  logic           r_wr, r_mod;

  assign r_ptr = idle ? req_ptr   : cur_ptr;
  assign r_idx = idle ? req_reg   : cur_reg;
  assign r_wr  = idle ? req_write : cur_write;

  iag_post_mod #(
    .AW(AW), .RIW(RIW),
    .INC_A(NREG - 4), .INC_B(NREG - 3), .SP_IDX(NREG - 2), .PC_IDX(NREG - 1)
  ) u_rule (
    .ptr_i(r_ptr), .idx_i(r_idx), .wr_i(r_wr),
    .addr_o(r_addr), .next_o(r_next), .mod_o(r_mod)
  );

  iag_pair_flag u_flag (
    .clk(clk), .rst(rst), .set_i(pair_set), .clr_i(instr_end), .flag_o(pair_mode)
  );

  iag_seq #(.AW(AW), .DW(DW), .BW(BW), .RIW(RIW)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_reg(req_reg), .req_write(req_write), .req_wdata(req_wdata),
    .pair_flag(pair_mode),
    .rule_addr(r_addr), .rule_next(r_next), .rule_mod(r_mod),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
    .idle(idle), .cur_ptr(cur_ptr), .cur_reg(cur_reg), .cur_write(cur_write),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .done(done), .operand(operand), .wb_en(wb_en)
  );

  assign wb_reg = cur_reg;
  assign wb_val = cur_ptr;
endmodule

// File: tb/indirect_addr_gen_bench.sv
module indirect_addr_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_reg = '0;
  logic [15:0] req_ptr = '0, req_wdata = '0;
  logic pair_set = 1'b0, instr_end = 1'b0;
  logic bus_rdy = 1'b1;
  logic [15:0] bus_rdata, bus_addr, bus_wdata, operand, wb_val;
  logic bus_rd, bus_wr, done, wb_en, pair_mode;
  logic [2:0] wb_reg;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + a[7:0] + 8'h11};
  endfunction

  assign bus_rdata = pat(bus_addr);

  indirect_addr_gen u_indirect_addr_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_reg(req_reg), .req_write(req_write),
    .req_ptr(req_ptr), .req_wdata(req_wdata), .pair_set(pair_set), .instr_end(instr_end),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .done(done), .operand(operand), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_val(wb_val), .pair_mode(pair_mode)
  );

  function automatic logic [15:0] e_addr(input logic [2:0] r, input logic wr, input logic [15:0] p);
    return (r == 3'd6 && wr) ? p - 16'd1 : p;
  endfunction
  function automatic logic [15:0] e_next(input logic [2:0] r, input logic wr, input logic [15:0] p);
    if (r == 3'd4 || r == 3'd5) return p + 16'd1;
    if (r == 3'd6) return wr ? p - 16'd1 : p + 16'd1;
    if (r == 3'd7 && !wr) return p + 16'd1;
    return p;
  endfunction
  function automatic logic e_mod(input logic [2:0] r, input logic wr);
    return (r >= 3'd4) && !(r == 3'd7 && wr);
  endfunction
  function automatic string rtag(input logic [2:0] r);
    if (r < 3'd4) return "R1";
    if (r < 3'd6) return "R2";
    if (r == 3'd6) return "R3";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_pair(input bit set, input bit clr);
    @(negedge clk);
    pair_set = set; instr_end = clr;
    @(negedge clk);
    pair_set = 1'b0; instr_end = 1'b0;
  endtask

  task automatic run_txn(input logic [2:0] r, input logic wr, input logic [15:0] p,
                         input logic [15:0] wd, input bit use_pair, input bit intrude,
                         input int stall_n, input bit rnd_rdy);
    logic [15:0] ba [4];
    logic [15:0] bwd;
    logic [15:0] a1, p1, a2, p2, exp_op, fin;
    int beats;
    bit got_done;
    bit dbl;
    dbl = use_pair && !wr;
    beats = 0; got_done = 0; bwd = '0;
    foreach (ba[i]) ba[i] = '0;
    if (use_pair) begin
      pulse_pair(1'b1, 1'b0);
      chk(pair_mode == 1'b1, "R6", 32'(pair_mode), 32'd1);
    end
    a1 = e_addr(r, wr, p); p1 = e_next(r, wr, p);
    a2 = e_addr(r, wr, p1); p2 = e_next(r, wr, p1);
    @(negedge clk);
    req_valid = 1'b1; req_reg = r; req_write = wr; req_ptr = p; req_wdata = wd;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done) begin got_done = 1; break; end
      if (intrude && c == 0) begin
        req_valid = 1'b1; req_reg = r + 3'd1; req_write = !wr; req_ptr = ~p;
      end
      if (c < stall_n) begin
        bus_rdy = 1'b0;
        chk((bus_rd || bus_wr) && bus_addr == a1, "R9", 32'(bus_addr), 32'(a1));
      end else begin
        bus_rdy = rnd_rdy ? ($urandom % 3 != 0) : 1'b1;
      end
      if ((bus_rd || bus_wr) && bus_rdy) begin
        if (beats < 4) ba[beats] = bus_addr;
        bwd = bus_wdata;
        beats++;
      end
    end
    bus_rdy = 1'b1;
    chk(got_done, "R10", 32'(got_done), 32'd1);
    chk(beats == (dbl ? 2 : 1), dbl ? "R7" : (wr ? "R5" : "R8"), 32'(beats), dbl ? 32'd2 : 32'd1);
    chk(ba[0] == a1, rtag(r), 32'(ba[0]), 32'(a1));
    fin = dbl ? p2 : p1;
    if (dbl) begin
      chk(ba[1] == a2, "R7", 32'(ba[1]), 32'(a2));
      exp_op = {pat(a2)[7:0], pat(a1)[7:0]};
      chk(operand == exp_op, "R7", 32'(operand), 32'(exp_op));
    end else if (!wr) begin
      exp_op = pat(a1);
      chk(operand == exp_op, "R8", 32'(operand), 32'(exp_op));
    end else begin
      chk(bwd == wd, "R5", 32'(bwd), 32'(wd));
    end
    chk(wb_en == e_mod(r, wr), rtag(r), 32'(wb_en), 32'(e_mod(r, wr)));
    if (e_mod(r, wr)) begin
      chk(wb_val == fin, rtag(r), 32'(wb_val), 32'(fin));
      chk(wb_reg == r, "R10", 32'(wb_reg), 32'(r));
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", 32'(done), 32'd0);
    if (intrude) begin
      for (int k = 0; k < 3; k++) begin
        chk(!bus_rd && !bus_wr && !done, "R11", 32'({bus_rd, bus_wr, done}), 32'd0);
        @(negedge clk);
      end
    end
    if (use_pair && wr) chk(pair_mode == 1'b1, "R5", 32'(pair_mode), 32'd1);
    pulse_pair(1'b0, 1'b1);
    chk(pair_mode == 1'b0, "R6", 32'(pair_mode), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!done && !wb_en && !bus_rd && !bus_wr && !pair_mode, "R12",
        32'({done, wb_en, bus_rd, bus_wr, pair_mode}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !bus_rd && !bus_wr && !pair_mode, "R12",
        32'({done, bus_rd, bus_wr, pair_mode}), 32'd0);

    // directed corners
    run_txn(3'd0, 1'b0, 16'h1234, 16'h0, 0, 0, 0, 0);   // R1
    run_txn(3'd3, 1'b1, 16'h00FF, 16'hBEEF, 0, 0, 0, 0); // R1 R5
    run_txn(3'd4, 1'b0, 16'hFFFF, 16'h0, 0, 0, 0, 0);   // R2 wrap
    run_txn(3'd5, 1'b1, 16'h2000, 16'hA5A5, 0, 0, 0, 0); // R2
    run_txn(3'd6, 1'b1, 16'h0000, 16'h1111, 0, 0, 0, 0); // R3 wrap down
    run_txn(3'd6, 1'b0, 16'h01F0, 16'h0, 0, 0, 0, 0);   // R3
    run_txn(3'd7, 1'b0, 16'h1000, 16'h0, 0, 0, 0, 0);   // R4
    run_txn(3'd7, 1'b1, 16'h1004, 16'h7777, 0, 0, 0, 0); // R4
    run_txn(3'd6, 1'b0, 16'h0300, 16'h0, 1, 0, 0, 0);   // R7 stack pair
    run_txn(3'd7, 1'b0, 16'hFFFF, 16'h0, 1, 0, 0, 0);   // R7 pc pair wrap
    run_txn(3'd2, 1'b0, 16'h0042, 16'h0, 1, 0, 0, 0);   // R7 unmodified pair
    run_txn(3'd6, 1'b1, 16'h0400, 16'hCAFE, 1, 0, 0, 0); // R5 store ignores pair
    run_txn(3'd4, 1'b0, 16'h0500, 16'h0, 0, 0, 5, 0);   // R9 stall
    run_txn(3'd5, 1'b0, 16'h0600, 16'h0, 1, 0, 3, 0);   // R9 stall in pair
    run_txn(3'd1, 1'b0, 16'h0700, 16'h0, 0, 1, 0, 0);   // R11 intrusion
    // R6: same-cycle set and clear
    pulse_pair(1'b1, 1'b1);
    chk(pair_mode == 1'b1, "R6", 32'(pair_mode), 32'd1);
    pulse_pair(1'b0, 1'b1);
    chk(pair_mode == 1'b0, "R6", 32'(pair_mode), 32'd0);
    // R6: cleared without an access, next load single beat
    pulse_pair(1'b1, 1'b0);
    pulse_pair(1'b0, 1'b1);
    run_txn(3'd4, 1'b0, 16'h0800, 16'h0, 0, 0, 0, 0);

    for (int t = 0; t < 400; t++) begin
      run_txn(3'($urandom % 8), 1'($urandom % 2), 16'($urandom), 16'($urandom),
              ($urandom % 3) == 0, ($urandom % 8) == 0, int'($urandom % 3), 1'b1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule